// File: doc/BRIEF.md
# Gray-Coded Linear Table Position Monitor

This block watches a linear translation table whose carriage reports its absolute position, one of sixty detented stops, as a 6-bit reflected binary Gray word. The word is first brought into the clock domain through a short flop chain and then decoded to a binary stop number. The stop number drives three registered zone flags (left, center, right), an end-of-travel alarm, and a pair of BCD digits that feed a two-digit display.

A register keeps the last valid stop. Every clock with a legal code compares the new stop against that register. If the new stop is higher, the table is reported as moving right. If it is lower, the table is reported as moving left. If it is the same, the previous report stays. A code that decodes to 0 or to any value above 60 is not a legal stop: an error flag rises, and every other output keeps its value until a legal code returns. A synchronous reset puts the monitor on the mid-travel stop, 30, and clears the movement report.

Top module: `pos_monitor`

## Requirements
- R1: While reset is high and on the first cycle after it, the outputs show stop 30: bcd_tens=3, bcd_units=0, zone_center=1, and zone_left, zone_right, end_alarm, move_left, move_right and code_err all 0.
- R2: For an input equal to g = N xor (N >> 1) with 1 ≤ N ≤ 60, bcd_tens and bcd_units show the decimal tens and units of N. Each digit is a plain 4-bit binary value in the range 0 to 9.
- R3: zone_left is 1 exactly when 1 ≤ N ≤ 19.
- R4: zone_center is 1 exactly when 20 ≤ N ≤ 39.
- R5: zone_right is 1 exactly when 41 ≤ N ≤ 60. At N = 40 all three zone flags are 0.
- R6: end_alarm is 1 exactly when N ≤ 4 or N ≥ 56.
- R7: A legal stop greater than the stored previous stop sets move_right and clears move_left.
- R8: A legal stop smaller than the stored previous stop sets move_left and clears move_right.
- R9: A legal stop equal to the stored previous stop leaves both movement flags unchanged.
- R10: A code decoding to 0, 61, 62 or 63 sets code_err, holds every other output, and leaves the stored previous stop unchanged. The next legal code clears code_err.
- R11: At most one zone flag is 1, and move_left and move_right are never both 1.
- R12: An input change first shows on the outputs after the third rising clock edge following it: two synchronizer stages plus one output register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset to stop 30 |
| gray_pos | input | 6 | Gray-coded table position |
| bcd_tens | output | 4 | Tens digit of the stop number |
| bcd_units | output | 4 | Units digit of the stop number |
| zone_left | output | 1 | Stop lies in 1..19 |
| zone_center | output | 1 | Stop lies in 20..39 |
| zone_right | output | 1 | Stop lies in 41..60 |
| end_alarm | output | 1 | Stop within four stops of either end |
| move_left | output | 1 | Last change in stop was downward |
| move_right | output | 1 | Last change in stop was upward |
| code_err | output | 1 | Current code is not a legal stop |

## Verification
A wrong bit in the previous-stop register cannot be seen directly at the ports. It shows up as a wrong movement flag on the next legal code that differs from the true previous stop, three edges after that code is applied. For this reason the sweeps go both upward and downward, and they cross the reset value from both sides. A decoder or BCD fault shows on the digits and zone flags at the fixed three-edge latency. Holding outputs across illegal codes is checked by following each illegal code with a repeat of the last legal stop, which must leave the movement flags exactly as they were.

// File: rtl/posmon_pkg.sv
package posmon_pkg;

    localparam int unsigned TRAVEL_STOPS = 60;
    localparam int unsigned POS_W        = $clog2(TRAVEL_STOPS + 1);

    typedef logic [POS_W-1:0] pos_t;

    localparam pos_t STOP_FIRST   = pos_t'(1);
    localparam pos_t STOP_LAST    = pos_t'(TRAVEL_STOPS);
    localparam pos_t HOME_STOP    = pos_t'(30);
    localparam pos_t CENTER_START = pos_t'(20);
    localparam pos_t CENTER_END   = pos_t'(40);
    localparam pos_t ALARM_BELOW  = pos_t'(5);
    localparam pos_t ALARM_ABOVE  = pos_t'(55);

    typedef struct packed {
        logic [3:0] tens;
        logic [3:0] units;
    } bcd2_t;

    typedef struct packed {
        logic left;
        logic center;
        logic right;
    } zone_t;

    typedef enum logic [1:0] {
        DIR_IDLE  = 2'b00,
        DIR_LEFT  = 2'b01,
        DIR_RIGHT = 2'b10
    } dir_t;

    function automatic pos_t bin_to_gray(input pos_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic logic stop_legal(input pos_t n);
        return (n >= STOP_FIRST) && (n <= STOP_LAST);
    endfunction

    function automatic zone_t classify(input pos_t n);
        zone_t z;
        z.left   = (n >= STOP_FIRST) && (n < CENTER_START);
        z.center = (n >= CENTER_START) && (n < CENTER_END);
        z.right  = (n > CENTER_END) && (n <= STOP_LAST);
        return z;
    endfunction

    function automatic logic near_end(input pos_t n);
        return (n < ALARM_BELOW) || (n > ALARM_ABOVE);
    endfunction

    // Shift-and-add-3 conversion into two decimal digits.
    function automatic bcd2_t to_bcd(input pos_t n);
        logic [POS_W+7:0] sh;
        sh = '0;
        sh[POS_W-1:0] = n;
        for (int i = 0; i < POS_W; i++) begin
            if (sh[POS_W+3:POS_W] >= 4'd5)
                sh[POS_W+3:POS_W] = sh[POS_W+3:POS_W] + 4'd3;
            if (sh[POS_W+7:POS_W+4] >= 4'd5)
                sh[POS_W+7:POS_W+4] = sh[POS_W+7:POS_W+4] + 4'd3;
            sh = sh << 1;
        end
        return '{tens: sh[POS_W+7:POS_W+4], units: sh[POS_W+3:POS_W]};
    endfunction

endpackage

// File: rtl/gray_sync.sv
module gray_sync
    import posmon_pkg::*;
#(
    parameter int unsigned STAGES  = 2,
    parameter pos_t        RST_VAL = '0
) (
    input  logic clk,
    input  logic rst,
    input  pos_t d,
    output pos_t q
);

    pos_t stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= RST_VAL;
        else     stage_q[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stage_q[s] <= RST_VAL;
            else     stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/gray_decode.sv
module gray_decode
    import posmon_pkg::*;
(
    input  pos_t gray,
    output pos_t bin,
    output logic legal
);

    // Each binary bit is the parity of the Gray bits at or above it.
    for (genvar b = 0; b < POS_W; b++) begin : g_bit
        assign bin[b] = ^gray[POS_W-1:b];
    end

    assign legal = stop_legal(bin);

endmodule

// File: rtl/pos_classifier.sv
module pos_classifier
    import posmon_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  pos_t  stop,
    input  logic  legal,
    output zone_t zone_q,
    output logic  alarm_q,
    output bcd2_t digits_q,
    output logic  err_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            zone_q   <= classify(HOME_STOP);
            alarm_q  <= near_end(HOME_STOP);
            digits_q <= to_bcd(HOME_STOP);
            err_q    <= 1'b0;
        end else begin
            err_q <= ~legal;
            if (legal) begin
                zone_q   <= classify(stop);
                alarm_q  <= near_end(stop);
                digits_q <= to_bcd(stop);
            end
        end
    end

endmodule

// File: rtl/dir_tracker.sv
module dir_tracker
    import posmon_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  pos_t stop,
    input  logic legal,
    output logic go_left,
    output logic go_right
);

    pos_t prev_q;
    dir_t dir_q;
    dir_t dir_d;

    always_comb begin
        dir_d = dir_q;
        if (stop > prev_q)      dir_d = DIR_RIGHT;
        else if (stop < prev_q) dir_d = DIR_LEFT;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= HOME_STOP;
            dir_q  <= DIR_IDLE;
        end else if (legal) begin
            prev_q <= stop;
            dir_q  <= dir_d;
        end
    end

    assign go_left  = (dir_q == DIR_LEFT);
    assign go_right = (dir_q == DIR_RIGHT);

endmodule

// File: rtl/pos_monitor.sv
module pos_monitor
    import posmon_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [POS_W-1:0]     gray_pos,
    output logic [3:0]           bcd_tens,
    output logic [3:0]           bcd_units,
    output logic                 zone_left,
    output logic                 zone_center,
    output logic                 zone_right,
    output logic                 end_alarm,
    output logic                 move_left,
    output logic                 move_right,
    output logic                 code_err
);

    pos_t  gray_s;
    pos_t  stop;
    logic  legal;
    zone_t zone_q;
    bcd2_t digits_q;

    gray_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (bin_to_gray(HOME_STOP))
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (gray_pos),
        .q   (gray_s)
    );

    gray_decode u_dec (
        .gray  (gray_s),
        .bin   (stop),
        .legal (legal)
    );

    pos_classifier u_cls (
        .clk      (clk),
        .rst      (rst),
        .stop     (stop),
        .legal    (legal),
        .zone_q   (zone_q),
        .alarm_q  (end_alarm),
        .digits_q (digits_q),
        .err_q    (code_err)
    );

    dir_tracker u_dir (
        .clk      (clk),
        .rst      (rst),
        .stop     (stop),
        .legal    (legal),
        .go_left  (move_left),
        .go_right (move_right)
    );

    assign bcd_tens    = digits_q.tens;
    assign bcd_units   = digits_q.units;
    assign zone_left   = zone_q.left;
    assign zone_center = zone_q.center;
    assign zone_right  = zone_q.right;

endmodule

// File: rtl/pos_monitor_checker.sv
module pos_monitor_checker (
    input logic       clk,
    input logic       rst,
    input logic [3:0] bcd_tens,
    input logic [3:0] bcd_units,
    input logic       zone_left,
    input logic       zone_center,
    input logic       zone_right,
    input logic       end_alarm,
    input logic       move_left,
    input logic       move_right,
    input logic       code_err
);

    assert_zone_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({zone_left, zone_center, zone_right}));

    assert_dir_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
        !(move_left && move_right));

    assert_units_decimal_R2: assert property (@(posedge clk) disable iff (rst)
        (bcd_units <= 4'd9) && (bcd_tens <= 4'd6));

    assert_left_tens_R3: assert property (@(posedge clk) disable iff (rst)
        zone_left |-> (bcd_tens <= 4'd1));

    assert_center_tens_R4: assert property (@(posedge clk) disable iff (rst)
        zone_center |-> (bcd_tens == 4'd2 || bcd_tens == 4'd3));

    assert_right_tens_R5: assert property (@(posedge clk) disable iff (rst)
        zone_right |-> (bcd_tens >= 4'd4));

    assert_alarm_not_center_R6: assert property (@(posedge clk) disable iff (rst)
        end_alarm |-> !zone_center);

    assert_hold_on_error_R10: assert property (@(posedge clk) disable iff (rst)
        code_err |-> ($stable(bcd_tens) && $stable(bcd_units) && $stable(zone_left)
                      && $stable(zone_center) && $stable(zone_right) && $stable(end_alarm)
                      && $stable(move_left) && $stable(move_right)));

endmodule

bind pos_monitor pos_monitor_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .bcd_tens    (bcd_tens),
    .bcd_units   (bcd_units),
    .zone_left   (zone_left),
    .zone_center (zone_center),
    .zone_right  (zone_right),
    .end_alarm   (end_alarm),
    .move_left   (move_left),
    .move_right  (move_right),
    .code_err    (code_err)
);

// File: tb/sim_pos_monitor.sv
`timescale 1ns/1ps
module sim_pos_monitor;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] gray_pos = 6'd0;
    logic [3:0] bcd_tens, bcd_units;
    logic       zone_left, zone_center, zone_right, end_alarm;
    logic       move_left, move_right, code_err;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    int exp_prev = 30;
    int exp_ml   = 0;
    int exp_mr   = 0;
    int last_n   = 30;

    always #5 clk = ~clk;

    pos_monitor u0 (
        .clk (clk), .rst (rst), .gray_pos (gray_pos),
        .bcd_tens (bcd_tens), .bcd_units (bcd_units),
        .zone_left (zone_left), .zone_center (zone_center), .zone_right (zone_right),
        .end_alarm (end_alarm), .move_left (move_left), .move_right (move_right),
        .code_err (code_err)
    );

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, actual, expected, $time);
        end
    endtask

    function automatic logic [5:0] gray_of(input int n);
        logic [5:0] b;
        b = 6'(n);
        return b ^ (b >> 1);
    endfunction

    task automatic check_stop(input int n, input string tag);
        check({tag, " R2 tens"},  int'(bcd_tens),  n / 10);
        check({tag, " R2 units"}, int'(bcd_units), n % 10);
        check({tag, " R3 left"},   int'(zone_left),   int'(n >= 1 && n <= 19));
        check({tag, " R4 center"}, int'(zone_center), int'(n >= 20 && n <= 39));
        check({tag, " R5 right"},  int'(zone_right),  int'(n >= 41 && n <= 60));
        check({tag, " R6 alarm"},  int'(end_alarm),   int'(n <= 4 || n >= 56));
        check({tag, " R7/R8 move_right"}, int'(move_right), exp_mr);
        check({tag, " R7/R8 move_left"},  int'(move_left),  exp_ml);
        check({tag, " R10 code_err"}, int'(code_err), 0);
    endtask

    task automatic apply_stop(input int n, input string tag);
        @(negedge clk);
        gray_pos = gray_of(n);
        repeat (4) @(negedge clk);
        if (n > exp_prev) begin exp_mr = 1; exp_ml = 0; end
        else if (n < exp_prev) begin exp_mr = 0; exp_ml = 1; end
        exp_prev = n;
        last_n = n;
        check_stop(n, tag);
    endtask

    task automatic apply_bad(input int v);
        @(negedge clk);
        gray_pos = gray_of(v);
        repeat (4) @(negedge clk);
        check("R10 err set", int'(code_err), 1);
        check("R10 tens hold", int'(bcd_tens), last_n / 10);
        check("R10 units hold", int'(bcd_units), last_n % 10);
        check("R10 move_right hold", int'(move_right), exp_mr);
        check("R10 move_left hold", int'(move_left), exp_ml);
    endtask

    task automatic check_reset_state(input string tag);
        check({tag, " R1 tens"}, int'(bcd_tens), 3);
        check({tag, " R1 units"}, int'(bcd_units), 0);
        check({tag, " R1 center"}, int'(zone_center), 1);
        check({tag, " R1 others"},
              int'({zone_left, zone_right, end_alarm, move_left, move_right, code_err}), 0);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        gray_pos = gray_of(45);
        repeat (3) @(negedge clk);
        check_reset_state("reset");
        rst = 1'b0;
        check_reset_state("first cycle");

        // Upward sweep, starting below the reset stop (R7, R8)
        for (int n = 1; n <= 60; n++) apply_stop(n, "up");
        // Downward sweep
        for (int n = 60; n >= 1; n--) apply_stop(n, "down");

        // Reset mid-run, previous stop returns to 30 (R1, R7)
        @(negedge clk);
        gray_pos = gray_of(45);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check_reset_state("mid reset");
        rst = 1'b0;
        exp_prev = 30; exp_ml = 0; exp_mr = 0;
        repeat (3) @(negedge clk);
        exp_prev = 45; exp_mr = 1; last_n = 45;
        check_stop(45, "after reset R7");

        // Illegal codes, then the same stop again (R10, R9)
        apply_bad(0);
        apply_stop(45, "R9 equal after err");
        apply_bad(61);
        apply_bad(62);
        apply_bad(63);
        apply_stop(45, "R9 equal again");
        apply_stop(12, "R8 jump down");
        apply_bad(0);
        apply_stop(12, "R9 equal left");

        // Latency of three edges (R12)
        @(negedge clk);
        gray_pos = gray_of(13);
        repeat (2) @(negedge clk);
        check("R12 unchanged after 2 edges", int'(bcd_units), 2);
        check("R12 move_left still", int'(move_left), 1);
        @(negedge clk);
        check("R12 changed after 3 edges", int'(bcd_units), 3);
        check("R12 move_right after 3 edges", int'(move_right), 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule